// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

A single-port synchronous memory model that can alternate between reads and writes in consecutive cycles without leaving the data bus idle. A command cycle samples the address, the transfer direction and the per-lane write enables on the rising clock edge. The data for that command moves two edges later: read data leaves a registered output, or write data is taken from the input port. Because reads and writes use the same two-cycle offset, there is no bus turnaround gap between them.

A command started with the load input low begins a burst of four. Each later cycle with the load input high steps to the next word of the aligned group of four. The step order is either linear or interleaved. A clock-hold input freezes every register, as though the edge had not happened. A load cycle with any chip select inactive starts a deselect and ends any burst. The bidirectional data pins are split into an input bus, an output bus and an output-enable signal.

Top module: `zt_sram`

## Requirements
- R1: While reset is held and right after it, data_oe_o is 0 and data_o is 0. Every word of the array reads back as zero until it is written.
- R2: A read command is taken on the edge where load_ni=0, the chip is selected and wr_ni=1. On the second unheld edge after that, data_o is loaded with the word at that address and data_oe_o is 1 for the cycle. At all other times data_o keeps the last word it read.
- R3: A write command is taken on the edge where load_ni=0, the chip is selected and wr_ni=0. The word is written from data_i as sampled on the second unheld edge after the command, and data_oe_o is 0 for that slot.
- R4: Lane j is bits [9j+8:9j] of the word. A write changes lane j only when lane_we_ni[j]=0 on the command or burst cycle. Lanes whose enable is 1 keep their old contents.
- R5: lane_we_ni is ignored on read commands, and a read changes no stored data.
- R6: A deselect is a cycle with load_ni=0 and the chip not selected. The chip is selected when sel_a_ni=0, sel_b_ni=0 and sel_c_i=1. Two unheld edges after a deselect, data_oe_o is 0 and nothing is written.
- R7: When hold_i=1 on an edge, all other inputs are ignored. data_o, data_oe_o, the pipeline and the burst state keep their values.
- R8: With burst_ilv_i=0, the n-th advance cycle (load_ni=1) after a load uses address bits [1:0] equal to (base+n) mod 4. Bits [3:2] stay those of the base, and the direction is that of the load.
- R9: With burst_ilv_i=1, the n-th advance uses address bits [1:0] equal to base XOR (n mod 4).
- R10: An advance cycle that follows a deselect, with no new load in between, issues no access: data_oe_o stays 0 and nothing is written.
- R11: A write followed in the very next cycle by a read of the same address returns the newly written word. No idle cycle is needed between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_i | input | 1 | Clock hold: 1 makes the edge have no effect |
| load_ni | input | 1 | 0 loads a new command, 1 advances the burst |
| wr_ni | input | 1 | 0 write, 1 read (sampled on load) |
| lane_we_ni | input | 4 | Per-lane write enables, active low |
| sel_a_ni | input | 1 | Chip select, active low |
| sel_b_ni | input | 1 | Chip select, active low |
| sel_c_i | input | 1 | Chip select, active high |
| burst_ilv_i | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| addr_i | input | 4 | Word address |
| data_i | input | 36 | Write data, sampled two edges after the command |
| data_o | output | 36 | Registered read data |
| data_oe_o | output | 1 | Read data valid and driving the bus |

## Verification
The hardest case to reach is a hold that lands in the middle of a burst while earlier commands are still in flight in the pipeline. The frozen edge must delay the in-flight read output and the pending write, and it must also delay the burst step. The stimulus starts bursts in both orders and inserts single and double hold cycles between advances. During each hold it drives conflicting loads, addresses and selects, so any leak past the hold shows up as a wrong address or a wrong enable. A reference pipeline and memory in the bench compute the expected bus value for every cycle.

// File: rtl/zts_pkg.sv
package zts_pkg;
  localparam int BURST_W = 2;

  function automatic logic [BURST_W-1:0] burst_offset(
    input logic [BURST_W-1:0] base,
    input logic [BURST_W-1:0] step,
    input logic               ilv
  );
    return ilv ? (base ^ step) : (base + step);
  endfunction
endpackage

// File: rtl/zts_cmd.sv
module zts_cmd #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_ni,
  input  logic              wr_ni,
  input  logic [LANES-1:0]  lane_we_ni,
  input  logic              sel_ok_i,
  input  logic              ilv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              vld_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  mask_o
);
  import zts_pkg::*;

  logic               act_q, wr_q;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q, cnt_nx;

  assign cnt_nx = cnt_q + 1'b1;

  always_comb begin
    if (!load_ni) begin
      vld_o  = sel_ok_i;
      wr_o   = ~wr_ni;
      addr_o = addr_i;
    end else begin
      vld_o  = act_q;
      wr_o   = wr_q;
      addr_o = {base_q[ADDR_W-1:BURST_W],
                burst_offset(base_q[BURST_W-1:0], cnt_nx, ilv_i)};
    end
    mask_o = (vld_o && wr_o) ? ~lane_we_ni : '0;  // lanes ignored on reads
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en_i) begin
      if (!load_ni) begin
        act_q  <= sel_ok_i;
        wr_q   <= ~wr_ni;
        base_q <= addr_i;
        cnt_q  <= '0;
      end else if (act_q) begin
        cnt_q  <= cnt_nx;
      end
    end
  end
endmodule

// File: rtl/zts_pipe.sv
module zts_pipe #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (en_i) begin
      q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) q[s] <= q[s-1];
    end
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/zts_array.sv
module zts_array #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              vld_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  mask_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              oe_o
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata_o <= '0;
      oe_o    <= 1'b0;
    end else if (en_i) begin
      oe_o <= vld_i && !wr_i;
      if (vld_i && wr_i) begin
        for (int j = 0; j < LANES; j++)
          if (mask_i[j]) mem[addr_i][j*LANE_W +: LANE_W] <= wdata_i[j*LANE_W +: LANE_W];
      end else if (vld_i) begin
        rdata_o <= mem[addr_i];
      end
    end
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int LAT    = 2,
  localparam int WORD_W = LANES * LANE_W,
  localparam int CMD_W  = 2 + ADDR_W + LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              load_ni,
  input  logic              wr_ni,
  input  logic [LANES-1:0]  lane_we_ni,
  input  logic              sel_a_ni,
  input  logic              sel_b_ni,
  input  logic              sel_c_i,
  input  logic              burst_ilv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] data_o,
  output logic              data_oe_o
);
  logic              en, sel_ok;
  logic              c_vld, c_wr, p_vld, p_wr;
  logic [ADDR_W-1:0] c_addr, p_addr;
  logic [LANES-1:0]  c_mask, p_mask;

  assign en     = ~hold_i;
  assign sel_ok = ~sel_a_ni & ~sel_b_ni & sel_c_i;

  zts_cmd #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk_i, .rst_ni, .en_i(en), .load_ni, .wr_ni, .lane_we_ni,
    .sel_ok_i(sel_ok), .ilv_i(burst_ilv_i), .addr_i,
    .vld_o(c_vld), .wr_o(c_wr), .addr_o(c_addr), .mask_o(c_mask)
  );

  zts_pipe #(.W(CMD_W), .STAGES(LAT)) u_pipe (
    .clk_i, .rst_ni, .en_i(en),
    .d_i({c_vld, c_wr, c_addr, c_mask}),
    .q_o({p_vld, p_wr, p_addr, p_mask})
  );

  zts_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i, .rst_ni, .en_i(en),
    .vld_i(p_vld), .wr_i(p_wr), .addr_i(p_addr), .mask_i(p_mask),
    .wdata_i(data_i), .rdata_o(data_o), .oe_o(data_oe_o)
  );
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int WORD_W = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hold_i,
  input logic              load_ni,
  input logic              wr_ni,
  input logic              sel_a_ni,
  input logic              sel_b_ni,
  input logic              sel_c_i,
  input logic [WORD_W-1:0] data_o,
  input logic              data_oe_o
);
  logic sel_ok;
  assign sel_ok = !sel_a_ni && !sel_b_ni && sel_c_i;

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!data_oe_o && data_o == '0)); // R1

  AST_READ_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !load_ni && sel_ok && wr_ni) ##1 !hold_i ##1 !hold_i |=> data_oe_o); // R2

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !load_ni && sel_ok && !wr_ni) ##1 !hold_i ##1 !hold_i |=> !data_oe_o); // R3

  AST_DESEL_TRISTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !load_ni && !sel_ok) ##1 !hold_i ##1 !hold_i |=> !data_oe_o); // R6

  AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> ($stable(data_o) && $stable(data_oe_o))); // R7

  AST_ADV_AFTER_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !load_ni && !sel_ok) ##1 (!hold_i && load_ni) ##1 !hold_i ##1 !hold_i
    |=> !data_oe_o); // R10
endmodule

bind zt_sram zt_sram_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i, .rst_ni, .hold_i, .load_ni, .wr_ni, .sel_a_ni, .sel_b_ni, .sel_c_i,
  .data_o, .data_oe_o
);

// File: tb/sim_zt_sram.sv
module sim_zt_sram;
  localparam logic [2:0] SEL_ON = 3'b001;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        hold_i = 1'b0, load_ni = 1'b1, wr_ni = 1'b1;
  logic [3:0]  lane_we_ni = 4'hF;
  logic        sel_a_ni = 1'b1, sel_b_ni = 1'b1, sel_c_i = 1'b0;
  logic        burst_ilv_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [35:0] data_i = '0;
  logic [35:0] data_o;
  logic        data_oe_o;

  always #4 clk_i = ~clk_i;

  zt_sram u0 (.*);

  int checks = 0, errors = 0, cnum = 0;
  string ph = "R1";
  bit done = 0;

  // reference model
  logic [35:0] ref_mem [16];
  logic        s1_v = 0, s1_w = 0, s2_v = 0, s2_w = 0;
  logic [3:0]  s1_a = 0, s2_a = 0, s1_we = 4'hF, s2_we = 4'hF;
  logic        b_act = 0, b_wr = 0;
  logic [3:0]  b_base = 0;
  logic [1:0]  b_cnt = 0;
  logic        exp_oe = 0;
  logic [35:0] exp_dat = '0;
  logic        prev_held = 0;

  function automatic logic [35:0] din(int c);
    logic [8:0] b = 9'(c * 37 + 5);
    return {b + 9'd3, b ^ 9'h1A5, b + 9'd1, b};
  endfunction

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", tag, act, exp, cnum);
    end
  endtask

  task automatic cyc(logic h, logic ld, logic wr, logic [3:0] we, logic [2:0] sel, logic [3:0] a);
    logic nv, nw; logic [3:0] na;
    string tag;
    @(negedge clk_i);
    tag = prev_held ? "R7" : ph;
    chk(tag, {35'b0, data_oe_o}, {35'b0, exp_oe});
    chk(tag, data_o, exp_dat);
    hold_i = h; load_ni = ld; wr_ni = wr; lane_we_ni = we;
    {sel_a_ni, sel_b_ni, sel_c_i} = sel; addr_i = a; data_i = din(cnum);
    @(posedge clk_i);
    cnum++;
    prev_held = h;
    if (!h) begin
      nv = 0; nw = 0; na = a;
      if (!ld) begin
        nv = (sel == SEL_ON); nw = !wr; na = a;
        b_act = nv; b_wr = !wr; b_base = a; b_cnt = 0;
      end else if (b_act) begin
        b_cnt = b_cnt + 2'd1; nv = 1; nw = b_wr;
        na = {b_base[3:2], burst_ilv_i ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
      end
      exp_oe = s2_v && !s2_w;
      if (exp_oe) exp_dat = ref_mem[s2_a];
      if (s2_v && s2_w)
        for (int j = 0; j < 4; j++)
          if (!s2_we[j]) ref_mem[s2_a][j*9 +: 9] = data_i[j*9 +: 9];
      s2_v = s1_v; s2_w = s1_w; s2_a = s1_a; s2_we = s1_we;
      s1_v = nv; s1_w = nw; s1_a = na; s1_we = we;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 1, 4'hF, 3'b101, 4'h0);
  endtask

  task automatic rd_sweep();
    for (int a = 0; a < 16; a++) cyc(0, 0, 1, 4'hF, SEL_ON, 4'(a));
    idle(3);
  endtask

  task automatic burst(logic wr, logic [3:0] base, int adv);
    cyc(0, 0, wr, 4'(base ^ 4'h3), SEL_ON, base);
    for (int k = 0; k < adv; k++) cyc(0, 1, ~wr, 4'(k * 5), 3'b100, 4'(~base));
  endtask

  initial begin
    for (int i = 0; i < 16; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk_i);
    chk("R1", {35'b0, data_oe_o}, 36'b0);
    chk("R1", data_o, 36'b0);
    rst_ni = 1'b1;
    ph = "R1"; rd_sweep();
    ph = "R3"; for (int a = 0; a < 16; a++) cyc(0, 0, 0, 4'h0, SEL_ON, 4'(a));
    ph = "R2"; rd_sweep();
    ph = "R4"; for (int m = 0; m < 16; m++) cyc(0, 0, 0, 4'(m), SEL_ON, 4'(m));
    rd_sweep();
    ph = "R5"; for (int a = 0; a < 16; a++) cyc(0, 0, 1, 4'h0, SEL_ON, 4'(a));
    rd_sweep();
    ph = "R11";
    for (int a = 0; a < 16; a++) begin
      cyc(0, 0, 0, 4'(a ^ 5), SEL_ON, 4'(a));
      cyc(0, 0, 1, 4'hF, SEL_ON, 4'(a));
    end
    idle(3);
    ph = "R6";
    for (int v = 0; v < 3; v++) begin
      for (int a = 0; a < 6; a++) begin
        cyc(0, 0, 1, 4'hF, SEL_ON, 4'(a));
        cyc(0, 0, a[0], 4'h0, (v == 0) ? 3'b101 : (v == 1) ? 3'b011 : 3'b000, 4'(a + 8));
        cyc(0, 0, 0, 4'h0, SEL_ON, 4'(a + 2));
      end
      idle(3);
      rd_sweep();
    end
    ph = "R8"; burst_ilv_i = 0;
    for (int b = 0; b < 16; b++) begin burst(0, 4'(b), 5); burst(1, 4'(b), 5); end
    idle(3); rd_sweep();
    ph = "R9"; burst_ilv_i = 1;
    for (int b = 0; b < 16; b++) begin burst(0, 4'(b), 5); burst(1, 4'(b), 5); end
    idle(3); rd_sweep();
    ph = "R7";
    for (int b = 0; b < 8; b++) begin
      burst_ilv_i = b[0];
      cyc(0, 0, b[1], 4'h0, SEL_ON, 4'(b * 3));
      cyc(1, 0, ~b[1], 4'h0, 3'b101, 4'(b + 1));
      cyc(0, 1, 1, 4'(b), SEL_ON, 4'h0);
      cyc(1, 0, 0, 4'h0, SEL_ON, 4'hF);
      cyc(1, 1, 1, 4'h0, 3'b000, 4'h7);
      cyc(0, 1, 1, 4'(~b), SEL_ON, 4'h0);
      cyc(0, 1, 0, 4'h0, SEL_ON, 4'h0);
      cyc(1, 0, 1, 4'h0, SEL_ON, 4'h2);
    end
    idle(4); rd_sweep();
    ph = "R10";
    for (int v = 0; v < 4; v++) begin
      cyc(0, 0, v[0], 4'h0, SEL_ON, 4'(v));
      cyc(0, 0, 1, 4'h0, 3'b011, 4'(v));
      cyc(0, 1, v[1], 4'h0, SEL_ON, 4'(v));
      cyc(0, 1, 0, 4'h0, SEL_ON, 4'(v));
      cyc(0, 1, 1, 4'h0, SEL_ON, 4'(v));
      idle(2);
    end
    rd_sweep();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not complete (got hang, expected end)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule